// File: doc/BRIEF.md
# I2S Microphone Receive Master

This block is the master side of an I2S link to a 24-bit digital microphone, and it only receives. It divides the system clock to make the serial bit clock and drives the word-select line itself. Each stereo frame is fixed at 64 bit-clock periods. Word-select is low for the first 32 periods, which is the left slot, and high for the next 32, which is the right slot. Serial data is sampled on each rising bit-clock edge. Each sample arrives MSB first and begins one bit-clock period after the word-select edge that opens its slot. The block takes the 24 sample bits and ignores the rest of the slot. It sign-extends the sample to 32 bits and presents it with a one-cycle valid strobe.

Left samples are always delivered. A right sample is delivered only when the keep-right input is high at the moment its last bit is captured. Dropping the enable input parks both clocks low and clears the slot position. Raising it again starts a new frame at the left slot.

A slot sequencer with four states tracks the position within each slot:
- `ST_IDLE`: the block is disabled.
- `ST_LEAD`: the first period of a slot, which carries no sample bit.
- `ST_DATA`: the 24 sample periods.
- `ST_TAIL`: the 7 trailing periods.

Its transitions are:
- IDLE to LEAD when enable is seen high.
- LEAD to DATA on the falling bit-clock edge that ends the lead period.
- DATA to TAIL on the falling edge after the 24th sample bit.
- TAIL to LEAD on the falling edge that ends the slot; the channel flips on this transition.
- Any state to IDLE when enable is low.

Top module: `i2s_mic_rx`

## Requirements
- R1: `sck` is the system clock divided by CLK_DIV (default 32) with 50% duty. After `en` is first seen high, `sck` rises on the CLK_DIV/2-th rising edge of `clk` and falls on the CLK_DIV-th.
- R2: `ws` changes only on the `clk` edge where `sck` falls. It stays low for 32 `sck` periods and then high for 32 periods, repeating.
- R3: After reset and after every re-enable, the first slot has `ws` low. This is the left channel, reported with `sample_right` = 0.
- R4: Within a slot, period 0 (counted from the `ws` edge) carries no sample bit. Periods 1 to 24 carry sample bits 23 down to 0, each sampled from `sd` on the `clk` edge where `sck` rises.
- R5: `sample_data` bits 23:0 hold the captured sample, and bits 31:24 are copies of bit 23.
- R6: `sample_valid` is high for exactly one `clk` cycle. That cycle starts at the edge where `sck` rises to capture the 24th bit, and `sample_data` is valid in the same cycle.
- R7: `sample_data` and `sample_right` stay unchanged between valid strobes.
- R8: When `keep_right` is 0 at the capture edge, a right-slot sample produces no strobe and leaves `sample_data` unchanged. When it is 1, the right sample is delivered with `sample_right` = 1.
- R9: When `en` is low at a `clk` edge, `sck` and `ws` are low after that edge. Re-enabling restarts the frame at left slot period 0.
- R10: The value of `sd` in slot period 0 and in periods 25 to 31 has no effect on any output.
- R11: While `rst_n` is low, `sck`, `ws`, `sample_valid`, `sample_right` and `sample_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Runs the bit clock and frame when high |
| keep_right | input | 1 | Delivers right-slot samples when high |
| sd | input | 1 | Serial data from the microphone |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, low = left slot |
| sample_data | output | 32 | Sign-extended sample |
| sample_right | output | 1 | Channel of the last delivered sample, 1 = right |
| sample_valid | output | 1 | One-cycle strobe for a new sample |

## Verification
Every output has a fixed due time. `sck` and `ws` are due on the edge after the enable-edge count reaches a multiple of CLK_DIV/2. A sample is due on the same edge that raises `sck` for bit 24 of its slot. The bench counts enabled `clk` edges in an integer and derives the expected `sck`, `ws`, strobe and data from that count. It drives `sd` from the same count on falling `clk` edges. It compares all outputs on every falling edge, half a cycle after each register update, so a result arriving one cycle early or late is caught in that cycle.

// File: rtl/i2s_mic_pkg.sv
package i2s_mic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2,
        ST_TAIL = 2'd3
    } slot_state_t;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_t;

endpackage

// File: rtl/i2s_sck_gen.sv
module i2s_sck_gen #(
    parameter int CLK_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] HALF_M1 = CW'(CLK_DIV / 2 - 1);
    localparam logic [CW-1:0] LAST    = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt;

    // Tick pulses announce what the coming clk edge will do to sck.
    assign rise_o = en_i && (cnt == HALF_M1);
    assign fall_o = en_i && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sck_o <= 1'b0;
        end else if (!en_i) begin
            cnt   <= '0;
            sck_o <= 1'b0;
        end else begin
            if (cnt == LAST) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
            if (rise_o) begin
                sck_o <= 1'b1;
            end else if (fall_o) begin
                sck_o <= 1'b0;
            end
        end
    end

    AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !sck_o); // R9
    AST_SCK_RISE_MID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> (cnt == HALF_M1 + CW'(1))); // R1
    AST_SCK_FALL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sck_o) && en_i && $past(en_i)) |-> (cnt == '0)); // R1

endmodule

// File: rtl/i2s_slot_fsm.sv
module i2s_slot_fsm
    import i2s_mic_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int DATA_BITS = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en_i,
    input  logic                         sck_i,
    input  logic                         fall_i,
    output slot_state_t                  state_o,
    output logic [$clog2(SLOT_BITS)-1:0] sbit_o,
    output chan_t                        chan_o
);
    localparam int SBW = $clog2(SLOT_BITS);
    localparam logic [SBW-1:0] LAST_DATA = SBW'(DATA_BITS);
    localparam logic [SBW-1:0] LAST_SLOT = SBW'(SLOT_BITS - 1);

    slot_state_t    state_q, state_n;
    logic [SBW-1:0] sbit_q, sbit_n;
    chan_t          chan_q, chan_n;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sbit_q  <= '0;
            chan_q  <= CH_LEFT;
        end else begin
            state_q <= state_n;
            sbit_q  <= sbit_n;
            chan_q  <= chan_n;
        end
    end

    // Next-state process: slot position advances on sck falling ticks
    always_comb begin
        state_n = state_q;
        sbit_n  = sbit_q;
        chan_n  = chan_q;
        if (!en_i) begin
            state_n = ST_IDLE;
            sbit_n  = '0;
            chan_n  = CH_LEFT;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_n = ST_LEAD;
                    sbit_n  = '0;
                    chan_n  = CH_LEFT;
                end
                ST_LEAD: begin
                    if (fall_i) begin
                        state_n = ST_DATA;
                        sbit_n  = sbit_q + SBW'(1);
                    end
                end
                ST_DATA: begin
                    if (fall_i) begin
                        sbit_n = sbit_q + SBW'(1);
                        if (sbit_q == LAST_DATA) begin
                            state_n = ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (fall_i) begin
                        if (sbit_q == LAST_SLOT) begin
                            state_n = ST_LEAD;
                            sbit_n  = '0;
                            chan_n  = (chan_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
                        end else begin
                            sbit_n = sbit_q + SBW'(1);
                        end
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    // Output process
    always_comb begin
        state_o = state_q;
        sbit_o  = sbit_q;
        chan_o  = chan_q;
    end

    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_q) |-> $fell(sck_i)); // R2
    AST_WS_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (chan_q == CH_LEFT)); // R9
    AST_LEAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |-> (sbit_q == '0)); // R4

endmodule

// File: rtl/i2s_sample_cap.sv
module i2s_sample_cap
    import i2s_mic_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int DATA_BITS = 24,
    parameter int OUT_BITS  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rise_i,
    input  logic                         sck_i,
    input  slot_state_t                  state_i,
    input  logic [$clog2(SLOT_BITS)-1:0] sbit_i,
    input  chan_t                        chan_i,
    input  logic                         keep_right_i,
    input  logic                         sd_i,
    output logic [OUT_BITS-1:0]          data_o,
    output logic                         right_o,
    output logic                         valid_o
);
    localparam int SBW = $clog2(SLOT_BITS);
    localparam int PAD = OUT_BITS - DATA_BITS;
    localparam logic [SBW-1:0] LAST_DATA = SBW'(DATA_BITS);

    logic [DATA_BITS-2:0] shreg;
    logic [DATA_BITS-1:0] word;
    logic                 take_bit;
    logic                 last_bit;
    logic                 deliver;

    assign take_bit = rise_i && (state_i == ST_DATA);
    assign last_bit = take_bit && (sbit_i == LAST_DATA);
    assign word     = {shreg, sd_i};
    assign deliver  = last_bit && ((chan_i == CH_LEFT) || keep_right_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (take_bit) begin
            shreg <= word[DATA_BITS-2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            right_o <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= deliver;
            if (deliver) begin
                data_o  <= {{PAD{word[DATA_BITS-1]}}, word};
                right_o <= (chan_i == CH_RIGHT);
            end
        end
    end

    AST_VALID_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(sck_i)); // R6
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(data_o) && $stable(right_o))); // R7
    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (data_o[OUT_BITS-1:DATA_BITS] == {PAD{data_o[DATA_BITS-1]}})); // R5

endmodule

// File: rtl/i2s_mic_rx.sv
module i2s_mic_rx
    import i2s_mic_pkg::*;
#(
    parameter int CLK_DIV   = 32,
    parameter int SLOT_BITS = 32,
    parameter int DATA_BITS = 24,
    parameter int OUT_BITS  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                keep_right,
    input  logic                sd,
    output logic                sck,
    output logic                ws,
    output logic [OUT_BITS-1:0] sample_data,
    output logic                sample_right,
    output logic                sample_valid
);
    localparam int SBW = $clog2(SLOT_BITS);

    logic                rise_tick;
    logic                fall_tick;
    logic                sck_int;
    slot_state_t         state;
    logic [SBW-1:0]      sbit;
    chan_t               chan;

    i2s_sck_gen #(.CLK_DIV(CLK_DIV)) sck_gen_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .sck_o  (sck_int),
        .rise_o (rise_tick),
        .fall_o (fall_tick)
    );

    i2s_slot_fsm #(.SLOT_BITS(SLOT_BITS), .DATA_BITS(DATA_BITS)) slot_fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .sck_i   (sck_int),
        .fall_i  (fall_tick),
        .state_o (state),
        .sbit_o  (sbit),
        .chan_o  (chan)
    );

    i2s_sample_cap #(
        .SLOT_BITS (SLOT_BITS),
        .DATA_BITS (DATA_BITS),
        .OUT_BITS  (OUT_BITS)
    ) sample_cap_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_i       (rise_tick),
        .sck_i        (sck_int),
        .state_i      (state),
        .sbit_i       (sbit),
        .chan_i       (chan),
        .keep_right_i (keep_right),
        .sd_i         (sd),
        .data_o       (sample_data),
        .right_o      (sample_right),
        .valid_o      (sample_valid)
    );

    assign sck = sck_int;
    assign ws  = (chan == CH_RIGHT);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!sck && !ws && !sample_valid)); // R11

endmodule

// File: tb/i2s_mic_rx_tb.sv
module i2s_mic_rx_tb_top;
    localparam int DIV   = 32;
    localparam int HALF  = DIV / 2;
    localparam int FRAME = DIV * 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        keep_right = 1'b0;
    logic        sd = 1'b0;
    logic        sck;
    logic        ws;
    logic [31:0] sample_data;
    logic        sample_right;
    logic        sample_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // model state
    int          k = 0;
    int          base = 0;
    logic        exp_sck = 0, exp_ws = 0, exp_valid = 0, exp_right = 0;
    logic [31:0] exp_data = '0;

    i2s_mic_rx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .keep_right   (keep_right),
        .sd           (sd),
        .sck          (sck),
        .ws           (ws),
        .sample_data  (sample_data),
        .sample_right (sample_right),
        .sample_valid (sample_valid)
    );

    always #10 clk = ~clk;

    function automatic logic [23:0] word_of(int idx, int ch);
        logic [23:0] w;
        case (idx)
            0: w = 24'h3A5C71;
            1: w = 24'hC0FFEE;
            2: w = 24'h800000;
            3: w = 24'h7FFFFF;
            default: w = 24'((idx * 32'h0002F1A7) + 32'h00000123);
        endcase
        if (ch != 0) w = w ^ 24'h5A5A5A;
        return w;
    endfunction

    function automatic logic [31:0] sext(logic [23:0] w);
        if (w >= 24'h800000) return 32'(w) - 32'h0100_0000;
        return 32'(w);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model: advanced on every rising clk edge
    always @(posedge clk) begin
        if (!rst_n) begin
            k = 0;
            exp_valid = 0; exp_right = 0; exp_data = '0;
        end else if (!en) begin
            k = 0;
            exp_valid = 0;
        end else begin
            int p, s, ch;
            k = k + 1;
            p  = (k / DIV) % 64;
            s  = p % 32;
            ch = p / 32;
            exp_valid = 0;
            if ((k % DIV) == HALF && s == 24 && (ch == 0 || keep_right)) begin
                exp_valid = 1;
                exp_right = (ch != 0);
                exp_data  = sext(word_of(base + k / FRAME, ch));
            end
        end
        exp_sck = rst_n && en && ((k % DIV) >= HALF);
        exp_ws  = rst_n && en && (((k / DIV) % 64) >= 32);
    end

    // SD driver (R10: lead and tail periods carry a toggling junk pattern)
    always @(negedge clk) begin
        int p, s, ch;
        p  = (k / DIV) % 64;
        s  = p % 32;
        ch = p / 32;
        if (s >= 1 && s <= 24) sd = word_of(base + k / FRAME, ch)[24 - s];
        else                   sd = ~sd;
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            chk("R1 sck", 32'(sck), 32'(exp_sck));
            chk("R2 R3 ws", 32'(ws), 32'(exp_ws));
            chk("R6 R8 valid", 32'(sample_valid), 32'(exp_valid));
            chk("R4 R5 R7 R10 data", sample_data, exp_data);
            chk("R3 R8 channel", 32'(sample_right), 32'(exp_right));
        end
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset values
        chk("R11 reset sck", 32'(sck), 32'd0);
        chk("R11 reset ws", 32'(ws), 32'd0);
        chk("R11 reset data", sample_data, 32'd0);
        chk("R11 reset valid", 32'(sample_valid), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // left-only operation over patterns: positive, negative, min, max
        base = 0;
        en = 1'b1;
        repeat (4 * FRAME + 3) @(negedge clk);
        // disable mid left slot of a frame
        repeat (20 * DIV) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk("R9 parked sck", 32'(sck), 32'd0);
        chk("R9 parked ws", 32'(ws), 32'd0);
        repeat (10) @(negedge clk);
        base = 10;
        en = 1'b1;
        repeat (2 * FRAME) @(negedge clk);
        // keep the right channel too
        keep_right = 1'b1;
        repeat (2 * FRAME + 5) @(negedge clk);
        keep_right = 1'b0;
        repeat (FRAME) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule